// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block is the control heart of a core that issues instructions in program order and lets them execute and finish out of order. Each cycle it may accept one decoded instruction, made of an operation class, one destination register and two source registers. It binds the instruction to a free functional unit of the matching class and then steps it through four phases. Issue waits for a free unit and for no other in-flight writer of the destination. Operand read waits until neither source still has an unwritten older producer. Execution is carried out by the unit itself, which raises a one-cycle done pulse at the end. Write-back waits until no older instruction still needs the previous value of the destination.

The controller holds one status record per functional unit and one result-status entry per architectural register. From these it derives three things each cycle: whether the offered instruction is taken and by which unit, which units may read their operands, and which unit may drive the single result bus. No values are forwarded. A consumer reads from the register file only after its producer has written back. The datapath, the register file and the units' arithmetic sit outside the block.

Top module: `sb_issue_scoreboard`

## Requirements
- R1: After reset every unit is idle. `in_ready` is 1 for any offered instruction, and `rd_grant` and `wb_grant` are all zero.
- R2: Class codes are 0 integer, 1 multiply, 2 add, 3 divide. Unit indices are 0 integer, 1 and 2 multiply, 3 add, 4 divide. An accepted instruction goes to the lowest-index free unit of its class, and `issue_unit` reports that index in the same cycle.
- R3: `in_ready` is 0 while no unit of the offered class is free. An instruction that is not accepted stays at the head, so issue remains in program order.
- R4: `in_ready` is 0 while an issued instruction that has not yet written back targets the offered destination (WAW).
- R5: A unit's `rd_grant` bit is 1 for exactly one cycle per instruction. That cycle comes no earlier than the cycle after issue, and only when no older, still-unwritten instruction has a source of this one as its destination. After such a producer writes back, the consumer can be granted in the following cycle.
- R6: A `fu_done` pulse marks the unit's execution as finished. Write-back can be granted no earlier than the next cycle.
- R7: A finished unit is not granted write-back while an older instruction that has not yet read its operands names that unit's destination as a source. The hold lifts in the cycle after that read grant.
- R8: At most one `wb_grant` bit is 1 per cycle, chosen as the lowest eligible unit index. `wb_reg` gives the granted unit's destination.
- R9: Write-back acts before issue in the same cycle. A unit freed by write-back, and a destination whose writer is writing back, can both be used by the instruction offered in that cycle.
- R10: A `fu_done` pulse for a unit that is idle, or that has not read its operands, or that has already finished, has no effect on later grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is offered |
| in_op | input | 2 | Operation class of the offered instruction |
| in_dst | input | REG_W | Destination register |
| in_src1 | input | REG_W | First source register |
| in_src2 | input | REG_W | Second source register |
| in_ready | output | 1 | The offered instruction can be accepted this cycle |
| issue_unit | output | FU_W | Unit receiving the instruction |
| rd_grant | output | NUM_FU | Per-unit permission to read operands |
| fu_done | input | NUM_FU | Per-unit end-of-execution pulse |
| wb_grant | output | NUM_FU | Per-unit permission to write its result |
| wb_reg | output | REG_W | Destination of the granted write |

## Verification
The first stimulus is a short dependent sequence. A long multiply feeds a divide, while a later add overwrites a register the divide has yet to read. This separates true dependences (RAW) from anti-dependences (WAR), which stall operand read and write-back respectively. Directed pairs then set a WAW stall against a structural stall. One of these pairs is a same-register re-issue that can only proceed if write-back is resolved ahead of issue. A long random stream over eight registers with idle gaps and stray done pulses comes last. It mixes all hazard kinds at once, and a reference model that tracks age order instead of unit tags judges it on every clock.

// File: rtl/sb_pkg.sv
package sb_pkg;
    parameter int NUM_REGS = 32;
    localparam int REG_W = $clog2(NUM_REGS);
    localparam int NUM_FU = 5;
    localparam int FU_W = $clog2(NUM_FU + 1);

    typedef logic [FU_W-1:0]  fu_id_t;
    typedef logic [REG_W-1:0] reg_id_t;

    // Index NUM_FU means "no unit".
    localparam fu_id_t FU_NONE = fu_id_t'(NUM_FU);

    typedef enum logic [1:0] {
        OPC_INT = 2'd0,
        OPC_MUL = 2'd1,
        OPC_ADD = 2'd2,
        OPC_DIV = 2'd3
    } op_class_e;

    // Unit index to class: 0 int, 1..2 mul, 3 add, 4 div.
    function automatic op_class_e fu_class(int idx);
        case (idx)
            0:       return OPC_INT;
            1, 2:    return OPC_MUL;
            3:       return OPC_ADD;
            default: return OPC_DIV;
        endcase
    endfunction

    typedef struct packed {
        logic      busy;
        op_class_e op;
        reg_id_t   fi;
        reg_id_t   fj;
        reg_id_t   fk;
        fu_id_t    qj;
        fu_id_t    qk;
        logic      rj;
        logic      rk;
        logic      rd_done;
        logic      ex_done;
    } fu_rec_t;
endpackage

// File: rtl/sb_lowest_pick.sv
module sb_lowest_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o,
    output logic         any_o
);
    logic found;

    always_comb begin
        gnt_o = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && !found) begin
                gnt_o[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    assign any_o = |req_i;
endmodule

// File: rtl/sb_issue_ctl.sv
module sb_issue_ctl
    import sb_pkg::*;
(
    input  op_class_e         op_i,
    input  logic              dst_pend_i,
    input  logic [NUM_FU-1:0] free_i,
    output logic              ready_o,
    output fu_id_t            unit_o
);
    logic [NUM_FU-1:0] cls_match;
    logic [NUM_FU-1:0] cand;
    logic [NUM_FU-1:0] pick;
    logic              any_free;

    for (genvar i = 0; i < NUM_FU; i++) begin : g_cls
        assign cls_match[i] = (fu_class(i) == op_i);
    end

    assign cand = cls_match & free_i;

    sb_lowest_pick #(.N(NUM_FU)) u_pick (
        .req_i (cand),
        .gnt_o (pick),
        .any_o (any_free)
    );

    always_comb begin
        unit_o = FU_NONE;
        for (int i = NUM_FU - 1; i >= 0; i--) begin
            if (pick[i]) unit_o = fu_id_t'(i);
        end
    end

    // Structural and WAW stalls both hold the head instruction.
    assign ready_o = any_free && !dst_pend_i;
endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb
    import sb_pkg::*;
(
    input  fu_rec_t [NUM_FU-1:0] fu_i,
    output logic    [NUM_FU-1:0] gnt_o,
    output logic                 any_o
);
    logic [NUM_FU-1:0] war_blk;
    logic [NUM_FU-1:0] elig;

    for (genvar u = 0; u < NUM_FU; u++) begin : g_war
        always_comb begin
            war_blk[u] = 1'b0;
            for (int f = 0; f < NUM_FU; f++) begin
                if (f != u && fu_i[f].busy &&
                    ((fu_i[f].rj && fu_i[f].fj == fu_i[u].fi) ||
                     (fu_i[f].rk && fu_i[f].fk == fu_i[u].fi))) begin
                    war_blk[u] = 1'b1;
                end
            end
        end
        assign elig[u] = fu_i[u].busy && fu_i[u].ex_done && !war_blk[u];
    end

    sb_lowest_pick #(.N(NUM_FU)) u_pick (
        .req_i (elig),
        .gnt_o (gnt_o),
        .any_o (any_o)
    );
endmodule

// File: rtl/sb_issue_scoreboard.sv
module sb_issue_scoreboard
    import sb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_op,
    input  logic [REG_W-1:0]  in_dst,
    input  logic [REG_W-1:0]  in_src1,
    input  logic [REG_W-1:0]  in_src2,
    output logic              in_ready,
    output logic [FU_W-1:0]   issue_unit,
    output logic [NUM_FU-1:0] rd_grant,
    input  logic [NUM_FU-1:0] fu_done,
    output logic [NUM_FU-1:0] wb_grant,
    output logic [REG_W-1:0]  wb_reg
);
    typedef struct packed {
        fu_rec_t [NUM_FU-1:0]   fu;
        fu_id_t  [NUM_REGS-1:0] rs;
    } state_t;

    function automatic state_t reset_state();
        state_t s;
        s = '0;
        for (int r = 0; r < NUM_REGS; r++) s.rs[r] = FU_NONE;
        for (int u = 0; u < NUM_FU; u++) begin
            s.fu[u].qj = FU_NONE;
            s.fu[u].qk = FU_NONE;
        end
        return s;
    endfunction

    localparam state_t STATE_RST = reset_state();

    state_t state_q, state_d;

    logic              wb_any;
    fu_id_t            wb_fu;
    logic [NUM_FU-1:0] fu_free;
    logic              dst_pend;
    logic              fire;
    fu_id_t            iss_unit;
    fu_id_t            src1_prod, src2_prod;

    // Write-back arbitration (WAR check inside)
    sb_wb_arb u_wb_arb (
        .fu_i  (state_q.fu),
        .gnt_o (wb_grant),
        .any_o (wb_any)
    );

    always_comb begin
        wb_fu  = FU_NONE;
        wb_reg = '0;
        for (int u = 0; u < NUM_FU; u++) begin
            if (wb_grant[u]) begin
                wb_fu  = fu_id_t'(u);
                wb_reg = state_q.fu[u].fi;
            end
        end
    end

    // Result status as seen after this cycle's write-back.
    function automatic fu_id_t rs_eff(input state_t s, input reg_id_t r,
                                      input logic wv, input reg_id_t wr);
        if (wv && wr == r) return FU_NONE;
        return s.rs[r];
    endfunction

    assign src1_prod = rs_eff(state_q, in_src1, wb_any, wb_reg);
    assign src2_prod = rs_eff(state_q, in_src2, wb_any, wb_reg);
    assign dst_pend  = (rs_eff(state_q, in_dst, wb_any, wb_reg) != FU_NONE);

    for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
        assign fu_free[u]  = !state_q.fu[u].busy || wb_grant[u];
        assign rd_grant[u] = state_q.fu[u].busy && state_q.fu[u].rj && state_q.fu[u].rk;
    end

    sb_issue_ctl u_issue (
        .op_i       (op_class_e'(in_op)),
        .dst_pend_i (dst_pend),
        .free_i     (fu_free),
        .ready_o    (in_ready),
        .unit_o     (iss_unit)
    );

    assign issue_unit = iss_unit;
    assign fire       = in_valid && in_ready;

    always_comb begin
        state_d = state_q;

        // Operand read and execution-complete bookkeeping
        for (int u = 0; u < NUM_FU; u++) begin
            if (rd_grant[u]) begin
                state_d.fu[u].rj      = 1'b0;
                state_d.fu[u].rk      = 1'b0;
                state_d.fu[u].rd_done = 1'b1;
            end
            if (fu_done[u] && state_q.fu[u].busy && state_q.fu[u].rd_done &&
                !state_q.fu[u].ex_done) begin
                state_d.fu[u].ex_done = 1'b1;
            end
        end

        // Write-back: free the unit, release waiting consumers
        if (wb_any) begin
            for (int u = 0; u < NUM_FU; u++) begin
                if (wb_grant[u]) begin
                    state_d.fu[u].busy    = 1'b0;
                    state_d.fu[u].rd_done = 1'b0;
                    state_d.fu[u].ex_done = 1'b0;
                end
                if (state_q.fu[u].busy && state_q.fu[u].qj == wb_fu) begin
                    state_d.fu[u].qj = FU_NONE;
                    state_d.fu[u].rj = 1'b1;
                end
                if (state_q.fu[u].busy && state_q.fu[u].qk == wb_fu) begin
                    state_d.fu[u].qk = FU_NONE;
                    state_d.fu[u].rk = 1'b1;
                end
            end
            if (state_q.rs[wb_reg] == wb_fu) state_d.rs[wb_reg] = FU_NONE;
        end

        // Issue comes after write-back
        if (fire) begin
            state_d.fu[iss_unit].busy    = 1'b1;
            state_d.fu[iss_unit].op      = op_class_e'(in_op);
            state_d.fu[iss_unit].fi      = in_dst;
            state_d.fu[iss_unit].fj      = in_src1;
            state_d.fu[iss_unit].fk      = in_src2;
            state_d.fu[iss_unit].qj      = src1_prod;
            state_d.fu[iss_unit].qk      = src2_prod;
            state_d.fu[iss_unit].rj      = (src1_prod == FU_NONE);
            state_d.fu[iss_unit].rk      = (src2_prod == FU_NONE);
            state_d.fu[iss_unit].rd_done = 1'b0;
            state_d.fu[iss_unit].ex_done = 1'b0;
            state_d.rs[in_dst]           = iss_unit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= STATE_RST;
        else        state_q <= state_d;
    end

    AST_WB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wb_grant)); // R8

    AST_ISSUE_OWNS_DST: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> state_q.rs[$past(in_dst)] == $past(iss_unit)); // R4

    for (genvar u = 0; u < NUM_FU; u++) begin : g_ast
        AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            rd_grant[u] |=> !rd_grant[u]); // R5

        AST_WB_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
            wb_grant[u] |-> state_q.fu[u].ex_done && state_q.fu[u].rd_done); // R6

        AST_WB_FREES_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
            wb_grant[u] |=> !state_q.fu[u].busy ||
                            $past(fire && iss_unit == fu_id_t'(u))); // R9

        AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
            (fu_done[u] && !state_q.fu[u].busy) |=> !state_q.fu[u].ex_done); // R10
    end
endmodule

// File: tb/sb_issue_scoreboard_tb_top.sv
module sb_issue_scoreboard_tb_top;
    import sb_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic [1:0]        in_op;
    logic [REG_W-1:0]  in_dst, in_src1, in_src2;
    logic              in_ready;
    logic [FU_W-1:0]   issue_unit;
    logic [NUM_FU-1:0] rd_grant, fu_done, wb_grant;
    logic [REG_W-1:0]  wb_reg;

    always #10 clk = ~clk;

    sb_issue_scoreboard dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .in_ready(in_ready), .issue_unit(issue_unit), .rd_grant(rd_grant),
        .fu_done(fu_done), .wb_grant(wb_grant), .wb_reg(wb_reg)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit timed_out = 0;
    int unsigned rng = 32'h1234_5678;

    // Reference model: age-ordered view, no unit tags
    bit m_busy[NUM_FU], m_read[NUM_FU], m_exd[NUM_FU];
    int m_dst[NUM_FU], m_s1[NUM_FU], m_s2[NUM_FU], m_seq[NUM_FU], m_tmr[NUM_FU];
    int seq_ctr = 0;
    int lat[NUM_FU] = '{1, 10, 10, 2, 12};

    int q_op[$], q_dst[$], q_s1[$], q_s2[$];
    int war_seen = 0, waw_seen = 0, struct_seen = 0, same_seen = 0, spur_seen = 0;

    function automatic int unsigned rnd();
        rng ^= rng << 13;
        rng ^= rng >> 17;
        rng ^= rng << 5;
        return rng;
    endfunction

    function automatic int cls(int u);
        if (u == 0) return 0;
        if (u <= 2) return 1;
        if (u == 3) return 2;
        return 3;
    endfunction

    function automatic bit any_busy();
        for (int u = 0; u < NUM_FU; u++) if (m_busy[u]) return 1;
        return 0;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0d exp=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic push(input int op, input int d, input int a, input int b);
        q_op.push_back(op); q_dst.push_back(d); q_s1.push_back(a); q_s2.push_back(b);
    endtask

    function automatic bit src_ready(int u, int s);
        for (int g = 0; g < NUM_FU; g++)
            if (g != u && m_busy[g] && m_seq[g] < m_seq[u] && m_dst[g] == s) return 0;
        return 1;
    endfunction

    function automatic bit war_block(int u);
        for (int f = 0; f < NUM_FU; f++)
            if (f != u && m_busy[f] && !m_read[f] && m_seq[f] < m_seq[u] &&
                (m_s1[f] == m_dst[u] || m_s2[f] == m_dst[u])) return 1;
        return 0;
    endfunction

    task automatic step(input bit allow_issue, input bit spur_en);
        bit [NUM_FU-1:0] dn, exp_rd, exp_wb;
        int wbu, exp_unit, op, d;
        bit exp_ready, waw, found, war_any;
        @(negedge clk);
        cyc++;
        if (cyc > 20000) begin
            if (!timed_out) check(0, "R5", "watchdog", cyc, 20000);
            timed_out = 1;
            return;
        end
        if (allow_issue && q_op.size() > 0) begin
            in_valid = 1'b1;
            in_op    = 2'(q_op[0]);
            in_dst   = reg_id_t'(q_dst[0]);
            in_src1  = reg_id_t'(q_s1[0]);
            in_src2  = reg_id_t'(q_s2[0]);
        end else begin
            in_valid = 1'b0;
            in_op    = 2'(rnd() % 4);
            in_dst   = reg_id_t'(rnd() % NUM_REGS);
            in_src1  = reg_id_t'(rnd() % NUM_REGS);
            in_src2  = reg_id_t'(rnd() % NUM_REGS);
        end
        dn = '0;
        for (int u = 0; u < NUM_FU; u++) begin
            if (m_tmr[u] > 0) begin
                m_tmr[u]--;
                if (m_tmr[u] == 0) dn[u] = 1'b1;
            end
        end
        if (spur_en && (rnd() % 6 == 0)) begin
            int su;
            su = int'(rnd() % NUM_FU);
            if (!(m_busy[su] && m_read[su] && !m_exd[su]) && !dn[su]) begin
                dn[su] = 1'b1;
                spur_seen++;
            end
        end
        fu_done = dn;
        #1;
        // Expected write-back
        wbu = -1; war_any = 0; exp_wb = '0;
        for (int u = 0; u < NUM_FU; u++) begin
            if (m_busy[u] && m_exd[u]) begin
                if (war_block(u)) war_any = 1;
                else if (wbu < 0) wbu = u;
            end
        end
        if (wbu >= 0) exp_wb[wbu] = 1'b1;
        if (war_any) war_seen++;
        // Expected operand reads
        for (int u = 0; u < NUM_FU; u++)
            exp_rd[u] = m_busy[u] && !m_read[u] && src_ready(u, m_s1[u]) && src_ready(u, m_s2[u]);
        // Expected issue
        op = int'(in_op); d = int'(in_dst);
        found = 0; exp_unit = NUM_FU;
        for (int u = 0; u < NUM_FU; u++)
            if (!found && cls(u) == op && (!m_busy[u] || u == wbu)) begin
                found = 1; exp_unit = u;
            end
        waw = 0;
        for (int g = 0; g < NUM_FU; g++)
            if (m_busy[g] && g != wbu && m_dst[g] == d) waw = 1;
        exp_ready = found && !waw;
        if (in_valid && waw) waw_seen++;
        if (in_valid && !found) struct_seen++;
        if (in_valid && exp_ready && wbu >= 0 && (exp_unit == wbu || d == m_dst[wbu]))
            same_seen++;

        if (in_valid && exp_ready && wbu >= 0 && (exp_unit == wbu || d == m_dst[wbu]))
            check(in_ready == exp_ready, "R9", "in_ready same-cycle", int'(in_ready), int'(exp_ready));
        else if (waw)
            check(in_ready == exp_ready, "R4", "in_ready waw", int'(in_ready), int'(exp_ready));
        else
            check(in_ready == exp_ready, "R3", "in_ready", int'(in_ready), int'(exp_ready));
        if (exp_ready)
            check(int'(issue_unit) == exp_unit, "R2", "issue_unit", int'(issue_unit), exp_unit);
        check(rd_grant == exp_rd, "R5", "rd_grant", int'(rd_grant), int'(exp_rd));
        if (war_any)
            check(wb_grant == exp_wb, "R7", "wb_grant war", int'(wb_grant), int'(exp_wb));
        else
            check(wb_grant == exp_wb, "R6 R8 R10", "wb_grant", int'(wb_grant), int'(exp_wb));
        if (wbu >= 0)
            check(int'(wb_reg) == m_dst[wbu], "R8", "wb_reg", int'(wb_reg), m_dst[wbu]);

        // Advance the model across the coming edge
        for (int u = 0; u < NUM_FU; u++) begin
            if (exp_rd[u]) begin
                m_read[u] = 1;
                m_tmr[u]  = lat[u];
            end
            if (dn[u] && m_busy[u] && m_read[u] && !m_exd[u] && !exp_rd[u]) m_exd[u] = 1;
        end
        if (wbu >= 0) begin
            m_busy[wbu] = 0; m_read[wbu] = 0; m_exd[wbu] = 0; m_tmr[wbu] = 0;
        end
        if (in_valid && exp_ready) begin
            m_busy[exp_unit] = 1; m_read[exp_unit] = 0; m_exd[exp_unit] = 0;
            m_dst[exp_unit] = q_dst[0]; m_s1[exp_unit] = q_s1[0]; m_s2[exp_unit] = q_s2[0];
            m_seq[exp_unit] = seq_ctr++;
            void'(q_op.pop_front()); void'(q_dst.pop_front());
            void'(q_s1.pop_front()); void'(q_s2.pop_front());
        end
    endtask

    task automatic drain(input bit rand_gaps, input bit spur_en);
        while (!timed_out && (q_op.size() > 0 || any_busy()))
            step(rand_gaps ? (rnd() % 4 != 0) : 1'b1, spur_en);
        repeat (3) if (!timed_out) step(1'b0, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_dst = '0;
        in_src1 = '0; in_src2 = '0; fu_done = '0;
        for (int u = 0; u < NUM_FU; u++) begin
            m_busy[u] = 0; m_read[u] = 0; m_exd[u] = 0; m_tmr[u] = 0;
            m_dst[u] = 0; m_s1[u] = 0; m_s2[u] = 0; m_seq[u] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: idle state under reset
        for (int op = 0; op < 4; op++) begin
            in_op = 2'(op); #1;
            check(in_ready == 1'b1, "R1", "in_ready reset", int'(in_ready), 1);
        end
        check(rd_grant == '0, "R1", "rd_grant reset", int'(rd_grant), 0);
        check(wb_grant == '0, "R1", "wb_grant reset", int'(wb_grant), 0);
        rst_n = 1'b1;

        // Dependent sequence: RAW on mul/div, WAR on r6 between div and add
        push(0, 6, 20, 20);
        push(0, 2, 21, 21);
        push(1, 0, 2, 4);
        push(2, 8, 6, 2);
        push(3, 10, 0, 6);
        push(2, 6, 8, 2);
        drain(1'b0, 1'b0);

        // WAW with same-cycle write-back/issue, then structural on multipliers
        push(3, 1, 2, 3);
        push(2, 1, 4, 5);
        push(2, 1, 1, 1);
        push(1, 7, 1, 2);
        push(1, 8, 3, 4);
        push(1, 9, 5, 6);
        push(0, 9, 9, 9);
        drain(1'b0, 1'b0);

        // Random stream over a small register set with gaps and stray done pulses
        for (int i = 0; i < 400; i++)
            push(int'(rnd() % 4), int'(rnd() % 8), int'(rnd() % 8), int'(rnd() % 8));
        drain(1'b1, 1'b1);

        check(waw_seen > 0, "R4", "waw stall exercised", waw_seen, 1);
        check(struct_seen > 0, "R3", "structural stall exercised", struct_seen, 1);
        check(war_seen > 0, "R7", "war hold exercised", war_seen, 1);
        check(same_seen > 0, "R9", "same-cycle release exercised", same_seen, 1);
        check(spur_seen > 0, "R10", "stray done exercised", spur_seen, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule